// File: doc/BRIEF.md
# Input State Duration Timer

This block measures how long a digital input stays at one level, counted in system clock cycles. It watches one pin of a small pin group. The watched pin is either its own home pin or a neighbour a few positions to either side. The selected level can be inverted, so that an active-low pulse is timed as a high state. The result then passes through a two-flop synchronizer.

On each level change after arming, the block latches two things: the length of the state that just ended and that state's level. It then raises a ready flag. In the both-states mode every change produces a result. In the high-only mode a result is produced only when a high period ends. A consumer polls the ready flag rather than the pin. It collects the result with a one-cycle read strobe, which clears the flag. If a second result lands before the read, it replaces the first and an overrun flag is set.

Top module: `pin_state_timer`

## Requirements
- R1: In the both-states mode, each level change of the watched signal after arming latches into `dur` the number of clock cycles the previous level was held at the pin, and restarts the count.
- R2: `dur_level` holds the level of the state whose length is in `dur`: 1 for high, 0 for low, taken after any inversion.
- R3: With `mode_hi_only` = 1, only the end of a high state produces a result; the end of a low state leaves `ready`, `dur` and `dur_level` unchanged.
- R4: With `invert` = 1, the pin level is inverted before timing, so a low pin period is measured and reported as a high state.
- R5: `src_ofs` is a signed two's-complement offset added to the home pin index `HOME_IDX`. Codes +1..+3 and -1..-3 select a neighbour. Code 0, code -4 (3'b100) and any offset that falls outside the pin group select the home pin.
- R6: `ready` goes to 1 on the clock edge that latches a result. It stays at 1 until a cycle with `rd_strobe` = 1 and no new result, which clears it.
- R7: A result latched while `ready` = 1 and `rd_strobe` = 0 replaces `dur`/`dur_level` and sets `overrun`; `rd_strobe` clears `overrun`.
- R8: The count saturates at 2^CNT_W-1 and does not wrap.
- R9: While `en` = 0 no result is latched. After `en` rises, the first level change only arms the block, and the partial state that was present at enable is discarded.
- R10: A pin change that is set up before rising edge k gives its result and `ready` on edge k+2 (synchronizer plus capture), not earlier.
- R11: After reset, `ready`, `overrun`, `dur` and `dur_level` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enable; low disarms the timer |
| mode_hi_only | input | 1 | 0: time both states, 1: time high states only |
| invert | input | 1 | Invert the selected pin before timing |
| src_ofs | input | OFS_W (3) | Signed offset of the watched pin from the home pin |
| pins | input | NUM_PINS (8) | Asynchronous pin group |
| rd_strobe | input | 1 | One-cycle read; clears ready and overrun |
| ready | output | 1 | New result available |
| overrun | output | 1 | A result was replaced before it was read |
| dur | output | CNT_W (32) | Length of the ended state in clock cycles |
| dur_level | output | 1 | Level of the ended state |

## Verification
The bench builds a six-bit counter so that saturation can be reached quickly. It holds a level well past the limit and expects the limit back; a counter that wraps would return a small value instead. It samples the cycle before and the cycle of the expected ready edge. A design with one sync stage too few or too many would be caught at those samples. The bench also checks arming: after enable, the first change must produce nothing, and a design that captured the partial state would report a spurious result. The offset tests toggle the home pin while a neighbour is selected, and use the reserved code -4. These catch a mux that decodes the offset as unsigned or indexes outside the pin group.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic {
    TM_BOTH      = 1'b0,
    TM_HIGH_ONLY = 1'b1
  } time_mode_e;
endpackage

// File: rtl/pst_src_select.sv
module pst_src_select #(
  parameter int NUM_PINS = 8,
  parameter int HOME_IDX = 3,
  parameter int OFS_W    = 3
) (
  input  logic [NUM_PINS-1:0] pins,
  input  logic [OFS_W-1:0]    src_ofs,
  input  logic                invert,
  output logic                sel_lvl
);
  localparam int NOFS = 1 << OFS_W;

  logic [NOFS-1:0] cand;

  // One candidate per offset code; codes that land outside the group,
  // the zero code and the most negative code fall back to the home pin.
  for (genvar g = 0; g < NOFS; g++) begin : g_cand
    localparam int OFFV = (g >= NOFS / 2) ? g - NOFS : g;
    localparam int TGT  = HOME_IDX + OFFV;
    if (g == NOFS / 2 || TGT < 0 || TGT >= NUM_PINS) begin : g_home
      assign cand[g] = pins[HOME_IDX];
    end else begin : g_nbr
      assign cand[g] = pins[TGT];
    end
  end

  assign sel_lvl = cand[src_ofs] ^ invert;
endmodule

// File: rtl/pst_edge_sync.sv
module pst_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic lvl,
  output logic prev_lvl,
  output logic chg
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q, prev_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d};
    prev_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= prev_d;
    end
  end

  assign lvl      = chain_q[STAGES-1];
  assign prev_lvl = prev_q;
  assign chg      = lvl ^ prev_q;
endmodule

// File: rtl/pst_dur_counter.sv
module pst_dur_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnt_en,
  input  logic             restart,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      if (restart)               cnt_d = CNT_ONE;
      else if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count = cnt_q;

  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_MAX && !restart) |=> cnt_q == CNT_MAX); // R8
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && restart) |=> cnt_q == CNT_ONE); // R1
endmodule

// File: rtl/pst_capture_reg.sv
module pst_capture_reg #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_vld,
  input  logic [CNT_W-1:0] cap_dur,
  input  logic             cap_lvl,
  input  logic             rd_strobe,
  output logic             ready,
  output logic             overrun,
  output logic [CNT_W-1:0] dur,
  output logic             dur_level
);
  logic             rdy_q, rdy_d;
  logic             ovr_q, ovr_d;
  logic [CNT_W-1:0] dur_q, dur_d;
  logic             lvl_q, lvl_d;

  always_comb begin
    dur_d = dur_q;
    lvl_d = lvl_q;
    rdy_d = rdy_q;
    ovr_d = ovr_q;
    if (rd_strobe) begin
      rdy_d = 1'b0;
      ovr_d = 1'b0;
    end
    if (cap_vld) begin
      dur_d = cap_dur;
      lvl_d = cap_lvl;
      rdy_d = 1'b1;
      if (rdy_q && !rd_strobe) ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      ovr_q <= 1'b0;
      dur_q <= '0;
      lvl_q <= 1'b0;
    end else begin
      rdy_q <= rdy_d;
      ovr_q <= ovr_d;
      dur_q <= dur_d;
      lvl_q <= lvl_d;
    end
  end

  assign ready     = rdy_q;
  assign overrun   = ovr_q;
  assign dur       = dur_q;
  assign dur_level = lvl_q;

  AST_READY_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_vld |=> ready); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && !cap_vld) |=> (!ready && !overrun)); // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_vld && ready && !rd_strobe) |=> overrun); // R7
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_vld |=> ($stable(dur) && $stable(dur_level))); // R3
endmodule

// File: rtl/pin_state_timer.sv
module pin_state_timer #(
  parameter int NUM_PINS    = 8,
  parameter int HOME_IDX    = 3,
  parameter int OFS_W       = 3,
  parameter int CNT_W       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                mode_hi_only,
  input  logic                invert,
  input  logic [OFS_W-1:0]    src_ofs,
  input  logic [NUM_PINS-1:0] pins,
  input  logic                rd_strobe,
  output logic                ready,
  output logic                overrun,
  output logic [CNT_W-1:0]    dur,
  output logic                dur_level
);
  import pst_pkg::*;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  time_mode_e mode;
  assign mode = time_mode_e'(mode_hi_only);

  logic sel_lvl, lvl, prev_lvl, chg;

  pst_src_select #(
    .NUM_PINS(NUM_PINS), .HOME_IDX(HOME_IDX), .OFS_W(OFS_W)
  ) u_src (
    .pins(pins), .src_ofs(src_ofs), .invert(invert), .sel_lvl(sel_lvl)
  );

  pst_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_int_n), .d(sel_lvl),
    .lvl(lvl), .prev_lvl(prev_lvl), .chg(chg)
  );

  // Arming: the first change after enable starts the count only.
  logic armed_q, armed_d;
  logic cap_vld;
  logic [CNT_W-1:0] count;

  always_comb begin
    armed_d = en & (armed_q | chg);
    cap_vld = en & armed_q & chg & ((mode == TM_BOTH) | prev_lvl);
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) armed_q <= 1'b0;
    else            armed_q <= armed_d;
  end

  pst_dur_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .cnt_en(en), .restart(chg), .count(count)
  );

  pst_capture_reg #(.CNT_W(CNT_W)) u_cap (
    .clk(clk), .rst_n(rst_int_n),
    .cap_vld(cap_vld), .cap_dur(count), .cap_lvl(prev_lvl),
    .rd_strobe(rd_strobe),
    .ready(ready), .overrun(overrun), .dur(dur), .dur_level(dur_level)
  );

  AST_DISARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
    !armed_q |=> ($stable(dur) && $stable(dur_level))); // R9
  AST_HIONLY_SKIPS_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    (mode_hi_only && chg && !prev_lvl) |=> $stable(dur)); // R3
  AST_LEVEL_MATCHES: assert property (@(posedge clk) disable iff (!rst_int_n)
    (cap_vld && !$past(lvl)) |=> !dur_level); // R2
endmodule

// File: tb/pin_state_timer_tb.sv
module pin_state_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 8;
  localparam int HOME       = 3;
  localparam int CW         = 6;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          en, mode_hi_only, invert, rd_strobe;
  logic [2:0]    src_ofs;
  logic [NPINS-1:0] pins;
  logic          ready, overrun, dur_level;
  logic [CW-1:0] dur;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pin_state_timer #(
    .NUM_PINS(NPINS), .HOME_IDX(HOME), .OFS_W(3), .CNT_W(CW), .SYNC_STAGES(2)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_hi_only(mode_hi_only),
    .invert(invert), .src_ofs(src_ofs), .pins(pins), .rd_strobe(rd_strobe),
    .ready(ready), .overrun(overrun), .dur(dur), .dur_level(dur_level)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Called at a negedge; leaves the bench at a negedge.
  task automatic do_reset(input logic hi_only, input logic inv, input logic [2:0] ofs);
    rst_n = 1'b0; en = 1'b0; rd_strobe = 1'b0; pins = '0;
    mode_hi_only = hi_only; invert = inv; src_ofs = ofs;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic hold(input int idx, input logic val, input int n);
    pins[idx] = val;
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_rd();
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
  endtask

  // Checks a pending result, reads it (one cycle) and checks the flag cleared.
  task automatic read_chk(input string tag, input int exp_dur, input int exp_lvl);
    chk({tag, " ready"}, ready, 1);
    chk({tag, " dur"}, dur, exp_dur);
    chk({tag, " level"}, dur_level, exp_lvl);
    pulse_rd();
    chk({tag, " ready cleared (R6)"}, ready, 0);
  endtask

  task automatic t_reset();
    do_reset(1'b0, 1'b0, 3'd0);
    chk("R11 ready", ready, 0);
    chk("R11 overrun", overrun, 0);
    chk("R11 dur", dur, 0);
    chk("R11 level", dur_level, 0);
  endtask

  task automatic t_disabled_and_arm();
    do_reset(1'b0, 1'b0, 3'd0);
    hold(HOME, 1'b1, 5);
    hold(HOME, 1'b0, 5);
    chk("R9 no capture while disabled", ready, 0);
    en = 1'b1;
    hold(HOME, 1'b1, 5);
    chk("R9 first change only arms", ready, 0);
    hold(HOME, 1'b0, 4);
    read_chk("R9 first result", 5, 1);
  endtask

  task automatic t_both_states();
    do_reset(1'b0, 1'b0, 3'd0);
    en = 1'b1;
    hold(HOME, 1'b1, 5);
    hold(HOME, 1'b0, 2);
    chk("R10 not ready one edge early", ready, 0);
    hold(HOME, 1'b0, 1);
    chk("R10 ready on third edge", ready, 1);
    hold(HOME, 1'b0, 4);
    read_chk("R1 high 5", 5, 1);
    hold(HOME, 1'b1, 6);
    read_chk("R1 low 8", 8, 0);
    hold(HOME, 1'b0, 4);
    read_chk("R2 high 7", 7, 1);
  endtask

  task automatic t_overrun();
    do_reset(1'b0, 1'b0, 3'd0);
    en = 1'b1;
    hold(HOME, 1'b1, 3);
    hold(HOME, 1'b0, 4);
    chk("R7 no overrun on first", overrun, 0);
    hold(HOME, 1'b1, 5);
    chk("R7 overrun set", overrun, 1);
    chk("R7 newest dur kept", dur, 4);
    chk("R7 newest level kept", dur_level, 0);
    pulse_rd();
    chk("R7 overrun cleared by read", overrun, 0);
    chk("R6 ready cleared by read", ready, 0);
  endtask

  task automatic t_high_only();
    do_reset(1'b1, 1'b0, 3'd0);
    en = 1'b1;
    hold(HOME, 1'b1, 3);
    hold(HOME, 1'b0, 6);
    read_chk("R3 high 3", 3, 1);
    hold(HOME, 1'b1, 5);
    chk("R3 low end ignored", ready, 0);
    hold(HOME, 1'b0, 4);
    read_chk("R3 high 5", 5, 1);
  endtask

  task automatic t_invert();
    do_reset(1'b1, 1'b1, 3'd0);
    en = 1'b1;
    hold(HOME, 1'b1, 3);
    hold(HOME, 1'b0, 8);
    chk("R4 inverted low end ignored", ready, 0);
    hold(HOME, 1'b1, 4);
    read_chk("R4 low pin measured high", 8, 1);
  endtask

  task automatic t_neighbour(input logic [2:0] ofs, input int idx, input string tag);
    do_reset(1'b0, 1'b0, ofs);
    en = 1'b1;
    if (idx != HOME) begin
      hold(HOME, 1'b1, 4);
      hold(HOME, 1'b0, 4);
      hold(HOME, 1'b1, 4);
      chk({tag, " home pin ignored"}, ready, 0);
    end
    hold(idx, 1'b1, 3);
    hold(idx, 1'b0, 5);
    read_chk(tag, 3, 1);
  endtask

  task automatic t_saturate();
    do_reset(1'b0, 1'b0, 3'd0);
    en = 1'b1;
    hold(HOME, 1'b1, 3);
    hold(HOME, 1'b0, 4);
    pulse_rd();
    hold(HOME, 1'b0, 75);
    hold(HOME, 1'b1, 4);
    read_chk("R8 saturated low", (1 << CW) - 1, 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_disabled_and_arm();
    t_both_states();
    t_overrun();
    t_high_only();
    t_invert();
    t_neighbour(3'sd3, HOME + 3, "R5 offset +3");
    t_neighbour(3'b101, HOME - 3, "R5 offset -3");
    t_neighbour(3'b100, HOME, "R5 offset -4 home");
    t_saturate();
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule